// File: doc/BRIEF.md
# Coefficient Size Category Encoder

This unit takes one signed 16-bit quantized transform coefficient per cycle. It produces the magnitude category and the amplitude bits that a baseline image entropy coder sends after each variable-length symbol. The category is the number of significant bits in the magnitude of the value. The amplitude field carries that many bits: a non-negative value appears unchanged, and a negative value appears in ones'-complement form, trimmed to the category width.

In DC mode the unit does not categorize the coefficient itself. It categorizes the difference between the coefficient and the DC coefficient of the previous block, which it holds in a predictor register. The predictor loads every accepted DC coefficient. A restart input clears it. Results come out registered, one cycle after the input strobe. Symbol lookup and bit packing happen downstream.

Top module: `coef_size_enc`

## Requirements
- R1: The category is the bit length of the magnitude of the categorized value. This equals 16 minus the leading-zero count of the 16-bit magnitude, and lies in the range 0 to 15.
- R2: A categorized value of zero yields category 0 and amplitude 0.
- R3: For a non-negative categorized value, the amplitude equals that value.
- R4: For a negative categorized value, the amplitude is the magnitude XORed with a mask of ones that covers the low category bits. This is the same as the value minus one, taken in those bits.
- R5: Every amplitude bit at or above bit position `category` is zero.
- R6: When `is_dc` is 1, the categorized value is `coef` minus the predictor, computed at 17 bits. A valid DC input loads the raw `coef` into the predictor. AC inputs and idle cycles leave the predictor unchanged.
- R7: `pred_clr` clears the predictor to zero. The clear already applies to a DC input in the same cycle, which then has the predictor 0 subtracted and afterwards loads its own `coef`.
- R8: `out_valid` follows `in_valid` with one cycle of latency. `out_cat` and `out_amp` change only after a valid input. After reset, all outputs are zero.
- R9: A categorized value beyond ±32767 saturates to ±32767. A positive overflow gives category 15 with amplitude 0x7FFF, and a negative overflow (including an AC input of -32768) gives category 15 with amplitude 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_clr | input | 1 | Clears the DC predictor (restart) |
| in_valid | input | 1 | Input coefficient strobe |
| is_dc | input | 1 | 1: DC coefficient (difference coded), 0: AC coefficient |
| coef | input | 16 | Signed coefficient |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_cat | output | 4 | Size category |
| out_amp | output | 16 | Amplitude bits, zero above the category width |

## Verification
The hardest cases to reach are DC differences that leave the 16-bit range. They only arise when the predictor holds one extreme and the next DC coefficient holds the other. The stimulus therefore sets up that predictor state first and sends the opposite extreme after it. It also sends a DC input in the same cycle as a restart, to show which predictor the subtraction uses. The full AC range is swept exhaustively. A long pseudo-random DC sequence runs against a model of the predictor kept in the bench.

// File: rtl/coef_size_enc.sv
module coef_size_enc #(
  parameter int CW   = 16,
  parameter int CATW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pred_clr,
  input  logic                 in_valid,
  input  logic                 is_dc,
  input  logic signed [CW-1:0] coef,
  output logic                 out_valid,
  output logic [CATW-1:0]      out_cat,
  output logic [CW-1:0]        out_amp
);
  localparam int DW = CW + 1;
  localparam logic [DW-1:0] LIM = {2'b00, {(CW-1){1'b1}}};

  logic signed [CW-1:0] prev_dc, pred_eff;
  logic signed [DW-1:0] diff;
  logic                 neg;
  logic [DW-1:0]        mag, mag_c;
  logic [CATW-1:0]      cat;
  logic [CW-1:0]        mask, amp;

  assign pred_eff = pred_clr ? '0 : prev_dc;
  assign diff  = is_dc ? ({coef[CW-1], coef} - {pred_eff[CW-1], pred_eff})
                       : {coef[CW-1], coef};
  assign neg   = diff[DW-1];
  assign mag   = neg ? (~diff + 1'b1) : diff;
  assign mag_c = (mag > LIM) ? LIM : mag;

  always_comb begin
    cat = '0;
    for (int i = 0; i < DW; i++)
      if (mag_c[i]) cat = CATW'(i + 1);
  end

  always_comb begin
    mask = '0;
    for (int i = 0; i < CW; i++)
      if (i < int'(cat)) mask[i] = 1'b1;
  end

  assign amp = neg ? (mag_c[CW-1:0] ^ mask) : mag_c[CW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_dc   <= '0;
      out_valid <= 1'b0;
      out_cat   <= '0;
      out_amp   <= '0;
    end else begin
      prev_dc   <= (in_valid && is_dc) ? coef : pred_eff;
      out_valid <= in_valid;
      if (in_valid) begin
        out_cat <= cat;
        out_amp <= amp;
      end
    end
  end

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R8
  AST_IDLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R8
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_cat) && $stable(out_amp)));  // R8
  AST_AMP_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_amp >> out_cat) == '0));  // R5
  AST_ZERO_CAT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_cat == '0) |-> (out_amp == '0));  // R2
  AST_PRED_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_clr && !(in_valid && is_dc)) |=> (prev_dc == '0));  // R7
  AST_PRED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_clr && !(in_valid && is_dc)) |=> $stable(prev_dc));  // R6
  AST_PRED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_dc) |=> (prev_dc == $past(coef)));  // R6
endmodule

// File: tb/sim_coef_size_enc.sv
module sim_coef_size_enc;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pred_clr = 1'b0, in_valid = 1'b0, is_dc = 1'b0;
  logic signed [15:0] coef = '0;
  logic out_valid;
  logic [3:0] out_cat;
  logic [15:0] out_amp;

  int checks = 0, fails = 0;
  int model_prev = 0;
  bit done = 0;

  always #10 clk = ~clk;

  coef_size_enc u0 (.clk(clk), .rst_n(rst_n), .pred_clr(pred_clr), .in_valid(in_valid),
                    .is_dc(is_dc), .coef(coef), .out_valid(out_valid),
                    .out_cat(out_cat), .out_amp(out_amp));

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(int c, bit dc, bit clr);
    int v, peff, ecat, eamp, m;
    string tag;
    peff = clr ? 0 : model_prev;
    v = dc ? c - peff : c;
    if (dc) model_prev = c; else model_prev = peff;
    if (v > 32767) v = 32767;
    if (v < -32767) v = -32767;
    m = (v < 0) ? -v : v;
    ecat = 0;
    while ((1 << ecat) <= m) ecat++;
    eamp = (v >= 0) ? v : ((v - 1) & ((1 << ecat) - 1));
    if (m == 32767 && (c - peff > 32767 || c - peff < -32767)) tag = "R9";
    else if (v == 0) tag = "R2";
    else if (v > 0) tag = "R3 R1 R5";
    else tag = "R4 R1 R5";
    if (dc) tag = {tag, " R6"};
    if (clr) tag = {tag, " R7"};
    @(negedge clk);
    coef = 16'(c); is_dc = dc; pred_clr = clr; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; pred_clr = 1'b0; is_dc = 1'b0;
    chk(out_valid === 1'b1, "R8 valid", int'(out_valid), 1);
    chk(out_cat === 4'(ecat) && out_amp === 16'(eamp), tag,
        int'({out_cat, out_amp}), (ecat << 16) | eamp);
  endtask

  task automatic idle_check();
    logic [3:0] c0;
    logic [15:0] a0;
    c0 = out_cat; a0 = out_amp;
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 idle valid", int'(out_valid), 0);
    chk(out_cat === c0 && out_amp === a0, "R8 hold", int'({out_cat, out_amp}), int'({c0, a0}));
  endtask

  task automatic clear_only();
    @(negedge clk);
    pred_clr = 1'b1;
    @(negedge clk);
    pred_clr = 1'b0;
    model_prev = 0;
  endtask

  initial begin
    for (int n = 0; n < 190000; n++) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && out_cat === 4'd0 && out_amp === 16'd0, "R8 reset",
        int'({out_valid, out_cat, out_amp}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R2 R3 R4 R5 R9: every AC value
    for (int c = -32768; c < 32768; c++) apply(c, 1'b0, 1'b0);
    idle_check();  // R8
    // R6: DC differences, AC does not touch the predictor
    apply(100, 1'b1, 1'b0);
    apply(50, 1'b1, 1'b0);
    apply(7, 1'b0, 1'b0);
    apply(50, 1'b1, 1'b0);
    idle_check();
    // R7: standalone clear, then a clear together with a DC input
    clear_only();
    apply(-3, 1'b1, 1'b0);
    apply(20, 1'b1, 1'b1);
    apply(20, 1'b1, 1'b0);
    // R9: differences outside the 16-bit range
    apply(32767, 1'b1, 1'b0);
    apply(-32768, 1'b1, 1'b0);
    apply(32767, 1'b1, 1'b0);
    apply(-1, 1'b1, 1'b0);
    // R6 sweep with occasional restarts
    for (int k = 0; k < 2000; k++)
      apply(((k * 7919) % 65536) - 32768, 1'b1, (k % 97) == 0);
    finish_run();
  end
endmodule